// File: doc/BRIEF.md
# Asynchronous CPU Register Bus Slave

This block lets an external processor read and write a bank of 32-bit registers through an asynchronous parallel bus. The bus has an active-low chip select, separate active-low read and write strobes, an 11-bit address, a 32-bit data bus and an active-low ready output. None of the bus signals is related to the system clock. The block moves the control pins into the clock domain through a synchronizer chain. The address and data pins go through a delay chain of the same depth, so that each synchronized strobe edge lines up with the bus contents that were present at the raw edge.

In a write, the address is taken at the falling edge of the strobe. The data is taken from the last sample before the rising edge, and the register is updated at that rising edge. In a read, the address is taken at the falling edge of the strobe. The read value is then placed on the data bus, and only after that is ready pulled low. Chip select may stay low across several cycles as long as both strobes return high between them. The data bus is split into input, output and output-enable ports, so that the tristate pad is placed at chip level. The output enable is gated directly by the raw chip-select and read-strobe pins.

Top module: `cpubus_slave`

## Requirements
- R1: After reset, `bus_rdy_n` is 1, `bus_data_oe` is 0, and every register reads back as zero.
- R2: While `bus_sel_n` is high, strobe activity produces no ready and changes no register.
- R3: A write to address n with n below NUM_REGS (default 16; register n sits at address n) stores the data present on `bus_data_i` during the last part of the strobe-low period into register n.
- R4: A read returns the contents of the addressed register on `bus_data_o`. `bus_data_oe` is high at least one clock before `bus_rdy_n` falls, and the value stays fixed while ready is low.
- R5: Every accepted cycle pulls `bus_rdy_n` low while its strobe is held. Ready returns high within 16 clocks of strobe release and is never low while both synchronized strobes are released.
- R6: `bus_data_oe` is 1 only while both `bus_sel_n` and `bus_rd_n` are low. It drops in the same instant the read strobe pin rises, and it stays 0 throughout write cycles.
- R7: With `bus_sel_n` held low, consecutive cycles separated only by strobe release all complete and take effect.
- R8: A cycle in which both strobes are low together produces no ready and changes no register.
- R9: Addresses at or above NUM_REGS read as zero and still complete with ready, and writes to them change no register.
- R10: If `bus_sel_n` rises while a write strobe is low, that write is dropped and ready returns high.
- R11: Changes on `bus_addr` after the write strobe falls are ignored. Changes on `bus_data_i` while the strobe is still low replace the earlier data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Active-low chip select |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_addr | input | 11 | Register address |
| bus_data_i | input | 32 | Data from the processor (pad input) |
| bus_data_o | output | 32 | Read data to the processor (pad output) |
| bus_data_oe | output | 1 | Pad output enable; the pad is high impedance when 0 |
| bus_rdy_n | output | 1 | Active-low cycle-complete indication |

## Verification
On every clock, the embedded properties check several rules against the synchronized control state. Ready must stay released while both strobes are idle. The internal drive enable must have been preceded by a selected read. Ready may only fall in a read after the data has been driven. A commit may only happen while the chip is selected and no read strobe is present. The register bank must change only where a mapped write points and never on an unmapped one. Only the bench scenarios can show the effects seen at the ports: edge-based capture when the address or data changes in mid-cycle, abandoned cycles (chip select dropped, both strobes together), back-to-back cycles under a held select, unmapped reads returning zero, and the register contents seen through later reads.

// File: rtl/cpubus_pkg.sv
package cpubus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_WR_SAMPLE = 3'd1,
      ST_WR_ACK    = 3'd2,
      ST_RD_FETCH  = 3'd3,
      ST_RD_DRIVE  = 3'd4,
      ST_RD_DONE   = 3'd5,
      ST_DISCARD   = 3'd6
   } cyc_state_e;

   function automatic int idx_width(input int depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/cpubus_sync.sv
module cpubus_sync #(
   parameter int             WIDTH     = 1,
   parameter int             STAGES    = 2,
   parameter logic [WIDTH-1:0] INIT_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cpubus_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("cpubus_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= INIT_VAL;
            else        chain_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= INIT_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cpubus_regfile.sv
module cpubus_regfile
   import cpubus_pkg::*;
#(
   parameter int ADDR_W   = 11,
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   localparam int IDX_W = idx_width(NUM_REGS);

   if (NUM_REGS < 1) begin : g_bad_depth
      $error("cpubus_regfile: NUM_REGS must be at least 1");
   end

   logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
   logic [IDX_W-1:0]                idx;
   logic                            hit;

   assign hit = (32'(addr) < NUM_REGS);
   assign idx = addr[IDX_W-1:0];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_q[r] <= '0;
         end else if (wr_en && hit && (32'(idx) == r)) begin
            regs_q[r] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (hit) rd_data = regs_q[idx];
   end

   // R9: a write outside the mapped range leaves the whole bank untouched
   p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hit) |=> $stable(regs_q));

   // R3: a mapped write lands in the addressed register
   p_mapped_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit) |=> (regs_q[$past(idx)] == $past(wr_data)));

   // R3: without a write the bank holds
   p_hold_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_q));

endmodule

// File: rtl/cpubus_ctrl.sv
module cpubus_ctrl
   import cpubus_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_sel_n,
   input  logic              s_wr_n,
   input  logic              s_rd_n,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [DATA_W-1:0] s_data,
   input  logic [DATA_W-1:0] rf_rdata,
   output logic [ADDR_W-1:0] rf_addr,
   output logic              wr_commit,
   output logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              drive_en,
   output logic              ready
);

   cyc_state_e        state_q;
   logic              sel_a, wr_a, rd_a;
   logic              wr_a_q, rd_a_q;
   logic              wr_fall, rd_fall;
   logic              rd_keep;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] rdata_q;
   logic              oe_q, rdy_q, commit_q;

   assign sel_a   = ~s_sel_n;
   assign wr_a    = ~s_wr_n;
   assign rd_a    = ~s_rd_n;
   assign wr_fall = wr_a & ~wr_a_q;
   assign rd_fall = rd_a & ~rd_a_q;
   assign rd_keep = sel_a & rd_a & ~wr_a;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         wr_a_q   <= 1'b0;
         rd_a_q   <= 1'b0;
         addr_q   <= '0;
         data_q   <= '0;
         rdata_q  <= '0;
         oe_q     <= 1'b0;
         rdy_q    <= 1'b0;
         commit_q <= 1'b0;
      end else begin
         wr_a_q   <= wr_a;
         rd_a_q   <= rd_a;
         commit_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               oe_q  <= 1'b0;
               rdy_q <= 1'b0;
               if (sel_a && (wr_fall || rd_fall)) begin
                  addr_q <= s_addr;
                  if (wr_a && rd_a) state_q <= ST_DISCARD;
                  else if (wr_a)    state_q <= ST_WR_SAMPLE;
                  else              state_q <= ST_RD_FETCH;
               end
            end
            ST_WR_SAMPLE: begin
               if (!sel_a || rd_a) begin
                  state_q <= ST_DISCARD;
               end else begin
                  data_q <= s_data;
                  if (!wr_a) begin
                     commit_q <= 1'b1;
                     state_q  <= ST_IDLE;
                  end else begin
                     rdy_q   <= 1'b1;
                     state_q <= ST_WR_ACK;
                  end
               end
            end
            ST_WR_ACK: begin
               if (!sel_a || rd_a) begin
                  rdy_q   <= 1'b0;
                  state_q <= ST_DISCARD;
               end else if (!wr_a) begin
                  rdy_q    <= 1'b0;
                  commit_q <= 1'b1;
                  state_q  <= ST_IDLE;
               end else begin
                  data_q <= s_data;
               end
            end
            ST_RD_FETCH: begin
               if (!rd_keep) begin
                  state_q <= ST_DISCARD;
               end else begin
                  rdata_q <= rf_rdata;
                  oe_q    <= 1'b1;
                  state_q <= ST_RD_DRIVE;
               end
            end
            ST_RD_DRIVE: begin
               if (!rd_keep) begin
                  oe_q    <= 1'b0;
                  state_q <= ST_DISCARD;
               end else begin
                  rdy_q   <= 1'b1;
                  state_q <= ST_RD_DONE;
               end
            end
            ST_RD_DONE: begin
               if (!rd_keep) begin
                  oe_q    <= 1'b0;
                  rdy_q   <= 1'b0;
                  state_q <= (wr_a || rd_a) ? ST_DISCARD : ST_IDLE;
               end
            end
            default: begin
               oe_q  <= 1'b0;
               rdy_q <= 1'b0;
               if (!wr_a && !rd_a) state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign rf_addr   = addr_q;
   assign wr_commit = commit_q;
   assign wr_data   = data_q;
   assign rd_data   = rdata_q;
   assign drive_en  = oe_q;
   assign ready     = rdy_q;

   // R5: with both strobes idle, ready is released on the next clock
   p_rdy_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_a && !rd_a) |=> !rdy_q);

   // R6: drive enable only follows a selected read strobe
   p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      oe_q |-> $past(sel_a && rd_a));

   // R4: in a read, data is on the bus before ready is raised
   p_data_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rdy_q) && (state_q == ST_RD_DONE)) |-> $past(oe_q));

   // R4: read data holds while the cycle is complete
   p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_RD_DONE) && $past(state_q == ST_RD_DONE)) |-> $stable(rdata_q));

   // R2: no commit without chip select
   p_commit_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |-> $past(sel_a));

   // R8: no commit while a read strobe is present
   p_commit_no_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |-> $past(!rd_a));

   // R3: a commit is a single-cycle pulse
   p_commit_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |=> !commit_q);

endmodule

// File: rtl/cpubus_slave.sv
module cpubus_slave
   import cpubus_pkg::*;
#(
   parameter int ADDR_W       = 11,
   parameter int DATA_W       = 32,
   parameter int NUM_REGS     = 16,
   parameter int SYNC_STAGES  = 2,
   parameter bit OE_PIN_GATE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel_n,
   input  logic              bus_wr_n,
   input  logic              bus_rd_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data_i,
   output logic [DATA_W-1:0] bus_data_o,
   output logic              bus_data_oe,
   output logic              bus_rdy_n
);

   localparam int PAY_W = ADDR_W + DATA_W;

   if (ADDR_W < 1 || ADDR_W > 30) begin : g_bad_addr
      $error("cpubus_slave: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("cpubus_slave: DATA_W must be positive");
   end
   if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_regs
      $error("cpubus_slave: NUM_REGS does not fit the address space");
   end

   logic [2:0]        ctl_sync;
   logic [PAY_W-1:0]  pay_sync;
   logic [ADDR_W-1:0] rf_addr;
   logic [DATA_W-1:0] rf_rdata;
   logic [DATA_W-1:0] wr_data;
   logic              wr_commit;
   logic              drive_en;
   logic              ready;

   cpubus_sync #(
      .WIDTH    (3),
      .STAGES   (SYNC_STAGES),
      .INIT_VAL (3'b111)
   ) u_ctl_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bus_sel_n, bus_wr_n, bus_rd_n}),
      .q     (ctl_sync)
   );

   cpubus_sync #(
      .WIDTH    (PAY_W),
      .STAGES   (SYNC_STAGES),
      .INIT_VAL ('0)
   ) u_pay_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bus_addr, bus_data_i}),
      .q     (pay_sync)
   );

   cpubus_ctrl #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_sel_n   (ctl_sync[2]),
      .s_wr_n    (ctl_sync[1]),
      .s_rd_n    (ctl_sync[0]),
      .s_addr    (pay_sync[PAY_W-1:DATA_W]),
      .s_data    (pay_sync[DATA_W-1:0]),
      .rf_rdata  (rf_rdata),
      .rf_addr   (rf_addr),
      .wr_commit (wr_commit),
      .wr_data   (wr_data),
      .rd_data   (bus_data_o),
      .drive_en  (drive_en),
      .ready     (ready)
   );

   cpubus_regfile #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (rf_addr),
      .wr_en   (wr_commit),
      .wr_data (wr_data),
      .rd_data (rf_rdata)
   );

   if (OE_PIN_GATE) begin : g_oe_pin
      assign bus_data_oe = drive_en & ~bus_sel_n & ~bus_rd_n;
   end else begin : g_oe_reg
      assign bus_data_oe = drive_en;
   end

   assign bus_rdy_n = ~ready;

   // R1: ready is released and the bus is not driven out of reset
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (bus_rdy_n && !bus_data_oe));

endmodule

// File: tb/cpubus_slave_bench.sv
module cpubus_slave_bench;

   localparam int NREG = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        rd_n = 1'b1;
   logic [10:0] addr = '0;
   logic [31:0] din = '0;
   logic [31:0] dout;
   logic        oe;
   logic        rdy_n;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;
   logic [31:0] model [NREG];

   always #10 clk = ~clk;

   cpubus_slave u_cpubus_slave (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_sel_n   (sel_n),
      .bus_wr_n    (wr_n),
      .bus_rd_n    (rd_n),
      .bus_addr    (addr),
      .bus_data_i  (din),
      .bus_data_o  (dout),
      .bus_data_oe (oe),
      .bus_rdy_n   (rdy_n)
   );

   typedef struct packed {
      logic        is_wr;
      logic [10:0] a;
      logic [31:0] d;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 11'd0,    32'hA5A5_0001},
      '{1'b1, 11'd5,    32'hDEAD_BEEF},
      '{1'b1, 11'd15,   32'hFFFF_FFFF},
      '{1'b1, 11'd16,   32'h1234_5678},
      '{1'b1, 11'd2047, 32'hCAFE_F00D},
      '{1'b0, 11'd0,    32'h0},
      '{1'b0, 11'd5,    32'h0},
      '{1'b0, 11'd15,   32'h0},
      '{1'b0, 11'd16,   32'h0},
      '{1'b0, 11'd2047, 32'h0},
      '{1'b1, 11'd5,    32'h0000_0000},
      '{1'b0, 11'd5,    32'h0},
      '{1'b1, 11'd1,    32'h8000_0001},
      '{1'b0, 11'd1,    32'h0},
      '{1'b0, 11'd15,   32'h0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] expect_rd(input logic [10:0] a);
      return (a < NREG) ? model[a] : 32'h0;
   endfunction

   task automatic wait_rdy(input logic lvl, output bit got);
      got = 1'b0;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         if (rdy_n == lvl) begin
            got = 1'b1;
            break;
         end
      end
   endtask

   task automatic do_write(input logic [10:0] a, input logic [31:0] d, input bit hold_sel);
      bit got;
      @(negedge clk); sel_n = 1'b0; addr = a; din = d;
      @(negedge clk); wr_n = 1'b0;
      wait_rdy(1'b0, got);
      chk("R5 write ready low", 32'(got), 32'd1);
      chk("R6 no drive in write", 32'(oe), 32'd0);
      repeat (2) @(negedge clk);
      wr_n = 1'b1;
      wait_rdy(1'b1, got);
      chk("R5 write ready released", 32'(got), 32'd1);
      repeat (2) @(negedge clk);
      if (!hold_sel) sel_n = 1'b1;
      if (a < NREG) model[a] = d;
   endtask

   task automatic do_read(input logic [10:0] a, output logic [31:0] d, input bit hold_sel);
      bit got;
      bit prev_oe;
      got = 1'b0;
      prev_oe = 1'b0;
      @(negedge clk); sel_n = 1'b0; addr = a;
      @(negedge clk); rd_n = 1'b0;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         if (rdy_n == 1'b0) begin
            got = 1'b1;
            break;
         end
         prev_oe = oe;
      end
      chk("R5 read ready low", 32'(got), 32'd1);
      chk("R4 drive before ready", 32'(prev_oe), 32'd1);
      chk("R6 drive during read", 32'(oe), 32'd1);
      d = dout;
      @(negedge clk);
      chk("R4 data held under ready", dout, d);
      rd_n = 1'b1;
      #1;
      chk("R6 drive drops with strobe", 32'(oe), 32'd0);
      wait_rdy(1'b1, got);
      chk("R5 read ready released", 32'(got), 32'd1);
      repeat (2) @(negedge clk);
      if (!hold_sel) sel_n = 1'b1;
   endtask

   task automatic idle_check(input string tag, input int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (rdy_n !== 1'b1) begin
            chk(tag, 32'(rdy_n), 32'd1);
            return;
         end
      end
      chk(tag, 32'(rdy_n), 32'd1);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] rv;
      for (int i = 0; i < NREG; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready idle after reset", 32'(rdy_n), 32'd1);
      chk("R1 no drive after reset", 32'(oe), 32'd0);
      do_read(11'd3, rv, 1'b0);
      chk("R1 register zero after reset", rv, 32'h0);

      // vector table: R3 writes, R4 mapped reads, R9 unmapped accesses
      for (int v = 0; v < NV; v++) begin
         if (VECS[v].is_wr) begin
            do_write(VECS[v].a, VECS[v].d, 1'b0);
         end else begin
            do_read(VECS[v].a, rv, 1'b0);
            if (VECS[v].a < NREG) chk("R3 R4 read back", rv, expect_rd(VECS[v].a));
            else                  chk("R9 unmapped reads zero", rv, 32'h0);
         end
      end
      do_read(11'd0, rv, 1'b0);
      chk("R9 unmapped write no alias", rv, model[0]);

      // R7: back-to-back cycles with chip select held low
      do_write(11'd3, 32'h0BAD_F00D, 1'b1);
      do_write(11'd4, 32'h1357_9BDF, 1'b1);
      do_read(11'd3, rv, 1'b1);
      chk("R7 held select first write", rv, 32'h0BAD_F00D);
      do_read(11'd4, rv, 1'b0);
      chk("R7 held select second write", rv, 32'h1357_9BDF);

      // R2: strobe without chip select
      @(negedge clk); sel_n = 1'b1; addr = 11'd6; din = 32'h6666_6666;
      @(negedge clk); wr_n = 1'b0;
      idle_check("R2 no ready unselected", 10);
      wr_n = 1'b1;
      repeat (4) @(negedge clk);
      do_read(11'd6, rv, 1'b0);
      chk("R2 no write unselected", rv, model[6]);

      // R8: both strobes together
      @(negedge clk); sel_n = 1'b0; addr = 11'd6; din = 32'h7777_7777;
      @(negedge clk); wr_n = 1'b0; rd_n = 1'b0;
      idle_check("R8 no ready both strobes", 10);
      chk("R8 no drive both strobes", 32'(oe), 32'd0);
      wr_n = 1'b1; rd_n = 1'b1;
      repeat (4) @(negedge clk);
      sel_n = 1'b1;
      do_read(11'd6, rv, 1'b0);
      chk("R8 no write both strobes", rv, model[6]);

      // R10: chip select removed during write strobe
      begin
         bit got;
         @(negedge clk); sel_n = 1'b0; addr = 11'd8; din = 32'h8888_8888;
         @(negedge clk); wr_n = 1'b0;
         wait_rdy(1'b0, got);
         chk("R10 ready before abort", 32'(got), 32'd1);
         sel_n = 1'b1;
         wait_rdy(1'b1, got);
         chk("R10 ready released on deselect", 32'(got), 32'd1);
         repeat (3) @(negedge clk);
         wr_n = 1'b1;
         repeat (4) @(negedge clk);
      end
      do_read(11'd8, rv, 1'b0);
      chk("R10 aborted write dropped", rv, model[8]);

      // R11: address moves after fall, data moves while strobe low
      begin
         bit got;
         @(negedge clk); sel_n = 1'b0; addr = 11'd7; din = 32'h1111_1111;
         @(negedge clk); wr_n = 1'b0;
         wait_rdy(1'b0, got);
         chk("R11 ready in write", 32'(got), 32'd1);
         addr = 11'd9; din = 32'h2222_2222;
         repeat (3) @(negedge clk);
         wr_n = 1'b1;
         wait_rdy(1'b1, got);
         repeat (2) @(negedge clk);
         sel_n = 1'b1;
         model[7] = 32'h2222_2222;
      end
      do_read(11'd7, rv, 1'b0);
      chk("R11 late data kept at latched address", rv, 32'h2222_2222);
      do_read(11'd9, rv, 1'b0);
      chk("R11 moved address untouched", rv, model[9]);

      // R1: reset in mid-run clears the bank
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 ready idle in reset", 32'(rdy_n), 32'd1);
      rst_n = 1'b1;
      for (int i = 0; i < NREG; i++) model[i] = '0;
      do_read(11'd5, rv, 1'b0);
      chk("R1 bank cleared by reset", rv, 32'h0);
      do_read(11'd7, rv, 1'b0);
      chk("R1 bank cleared by reset", rv, 32'h0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule